// File: doc/BRIEF.md
# Framed Transparent Bit Transmitter

This block turns buffers of bytes held in a word-wide memory into a serial bit stream on one data line. It sends one bit for each pulse of a transmit clock enable. Buffers are handed over one at a time as descriptors through a valid/ready handshake. Each descriptor carries a byte start address, a byte count, a frame-end flag and an event flag. Every byte of a buffer is fetched through a read port that returns one 16-bit word per request, one cycle after the request. A buffer may start at any byte address and may hold any number of bytes.

Between frames the line rests at continuous ones and the request-to-send output is low. After a descriptor is accepted the block holds its data back until a sync strobe arrives. It then raises request-to-send and shifts the bytes out, most significant bit first, or least significant bit first when the reversal input is set. A buffer without the frame-end flag hands straight over to the next descriptor with request-to-send still high. A completed buffer with its event flag set raises a sticky event bit. Writing a one to the event bit clears it. A mask gates the event bit onto an interrupt output.

Top module: `tfs_top`

## Requirements
- R1: After reset, and after a buffer that has the frame-end flag completes, `txd` is 1 on every bit time until another buffer starts sending after a sync strobe.
- R2: `rts` rises on the clock edge after the `sync_strobe` that starts a buffer. It stays high while that buffer's bits are sent. It falls on the bit time that follows the final bit of a buffer that has the frame-end flag. On that same bit time `txd` is 1.
- R3: An accepted buffer sends nothing before the next `sync_strobe`: bit times in that wait give `txd` = 1. A `sync_strobe` while no buffer is waiting has no effect.
- R4: The start address and the length may each be odd or even. Byte address A sits in word A>>1, in bits 15:8 when A is even and in bits 7:0 when A is odd. Exactly the bytes from address A to A+L-1 are sent, in rising address order. Exactly the ((A+L-1)>>1) - (A>>1) + 1 words spanned are read; for example, A=5 and L=10 takes six reads.
- R5: Each byte is sent most significant bit first, one bit for each `bit_en` pulse, with no gap between the bytes of a buffer. `txd` changes only on a clock edge where `bit_en` is high.
- R6: When `rev_bits` is 1, each byte is sent least significant bit first.
- R7: When a buffer that has its event flag set completes, `tx_event` becomes 1. It stays 1 until `evt_clear` is pulsed high; a completion in the same cycle as a clear wins. A buffer without the event flag leaves `tx_event` unchanged.
- R8: `tx_irq` is 1 exactly when `tx_event` and `evt_mask` are both 1.
- R9: After a buffer without the frame-end flag completes, `rts` stays high, `txd` sends ones, and `desc_ready` is high. The next buffer starts after its own sync strobe.
- R10: A descriptor is taken in a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` is low from then until that buffer completes. Memory reads happen only while a buffer is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | A ready descriptor is presented |
| desc_ready | output | 1 | Block can accept a descriptor |
| desc_addr | input | ADDR_W | Byte start address of the buffer |
| desc_len | input | LEN_W | Byte count of the buffer |
| desc_last | input | 1 | Buffer closes the frame |
| desc_irq | input | 1 | Raise the event when the buffer is done |
| sync_strobe | input | 1 | Synchronization reached |
| bit_en | input | 1 | Transmit bit clock enable |
| rev_bits | input | 1 | Send each byte least significant bit first |
| mem_rd_en | output | 1 | Word read request |
| mem_rd_waddr | output | ADDR_W-1 | Word address of the read |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| txd | output | 1 | Serial data line |
| rts | output | 1 | Request-to-send |
| evt_clear | input | 1 | Write-one-to-clear for the event bit |
| evt_mask | input | 1 | Interrupt enable for the event bit |
| tx_event | output | 1 | Sticky transmit event bit |
| tx_irq | output | 1 | Masked interrupt |

## Verification
The bench sweeps all four start alignments against short lengths in both bit orders, and adds an odd-aligned ten-byte buffer. A design that did not skip the first half-word would send a stale byte first. One that did not trim the last word would send an extra byte. Either fault, or a spare word fetch, shows up in the bit stream or in the read count. Bit times before the sync strobe and after the frame end are checked for ones with `rts` low, which catches a buffer that starts early or a frame end that keeps `rts` high. A chained pair checks that `rts` holds across the hand-over, and that the event bit is sticky, cleared on request and gated by the mask.

// File: rtl/tfs_pkg.sv
package tfs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_SEND
    } tfs_state_e;

    function automatic logic [7:0] flip8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction
endpackage

// File: rtl/tfs_fetch.sv
module tfs_fetch #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len,
    output logic              rd_en,
    output logic [ADDR_W-2:0] rd_waddr,
    input  logic [15:0]       rd_data,
    output logic              byte_valid,
    output logic [7:0]        byte_data,
    input  logic              byte_pop,
    output logic              empty
);
    localparam int WA_W = ADDR_W - 1;

    typedef struct packed {
        logic [WA_W-1:0]  waddr;
        logic             skip;
        logic [LEN_W-1:0] rem;
        logic [15:0]      word;
        logic [1:0]       vmask;
        logic             pend;
    } fetch_t;

    fetch_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        rd_en = 1'b0;
        if (start) begin
            st_d.waddr = start_addr[ADDR_W-1:1];
            st_d.skip  = start_addr[0];
            st_d.rem   = start_len;
            st_d.vmask = 2'b00;
            st_d.pend  = 1'b0;
        end else begin
            if (byte_pop) begin
                if (st_q.vmask[1]) st_d.vmask[1] = 1'b0;
                else               st_d.vmask[0] = 1'b0;
            end
            if (st_q.pend) begin
                st_d.word = rd_data;
                st_d.pend = 1'b0;
                st_d.skip = 1'b0;
                if (st_q.skip) begin
                    st_d.vmask = 2'b01;
                    st_d.rem   = st_q.rem - LEN_W'(1);
                end else if (st_q.rem == LEN_W'(1)) begin
                    st_d.vmask = 2'b10;
                    st_d.rem   = '0;
                end else begin
                    st_d.vmask = 2'b11;
                    st_d.rem   = st_q.rem - LEN_W'(2);
                end
            end else if (st_q.vmask == 2'b00 && st_q.rem != '0) begin
                rd_en      = 1'b1;
                st_d.pend  = 1'b1;
                st_d.waddr = st_q.waddr + WA_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_waddr   = st_q.waddr;
    assign byte_valid = |st_q.vmask;
    assign byte_data  = st_q.vmask[1] ? st_q.word[15:8] : st_q.word[7:0];
    assign empty      = (st_q.rem == '0) && (st_q.vmask == 2'b00) && !st_q.pend;
endmodule

// File: rtl/tfs_shift.sv
module tfs_shift
    import tfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       active,
    input  logic       rev,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    input  logic       fetch_empty,
    output logic       byte_pop,
    output logic       done,
    output logic       txd
);
    typedef struct packed {
        logic [7:0] sh;
        logic [2:0] cnt;
        logic       txd;
    } shift_t;

    shift_t st_d, st_q;
    logic [7:0] ordered;

    always_comb begin
        st_d     = st_q;
        byte_pop = 1'b0;
        done     = 1'b0;
        ordered  = rev ? flip8(byte_data) : byte_data;
        if (bit_en) begin
            if (!active) begin
                st_d.txd = 1'b1;
            end else if (st_q.cnt != 3'd0) begin
                st_d.txd = st_q.sh[7];
                st_d.sh  = {st_q.sh[6:0], 1'b0};
                st_d.cnt = st_q.cnt - 3'd1;
            end else if (byte_valid) begin
                byte_pop = 1'b1;
                st_d.txd = ordered[7];
                st_d.sh  = {ordered[6:0], 1'b0};
                st_d.cnt = 3'd7;
            end else begin
                st_d.txd = 1'b1;
                done     = fetch_empty;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{sh: 8'h00, cnt: 3'd0, txd: 1'b1};
        else        st_q <= st_d;
    end

    assign txd = st_q.txd;
endmodule

// File: rtl/tfs_top.sv
module tfs_top
    import tfs_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              desc_valid,
    output logic              desc_ready,
    input  logic [ADDR_W-1:0] desc_addr,
    input  logic [LEN_W-1:0]  desc_len,
    input  logic              desc_last,
    input  logic              desc_irq,
    input  logic              sync_strobe,
    input  logic              bit_en,
    input  logic              rev_bits,
    output logic              mem_rd_en,
    output logic [ADDR_W-2:0] mem_rd_waddr,
    input  logic [15:0]       mem_rd_data,
    output logic              txd,
    output logic              rts,
    input  logic              evt_clear,
    input  logic              evt_mask,
    output logic              tx_event,
    output logic              tx_irq
);
    typedef struct packed {
        tfs_state_e state;
        logic       rts;
        logic       evt;
        logic       last;
        logic       irq;
    } ctl_t;

    ctl_t st_d, st_q;

    logic       fetch_start;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       byte_pop;
    logic       fetch_empty;
    logic       buf_done;
    logic       set_evt;

    always_comb begin
        st_d        = st_q;
        set_evt     = 1'b0;
        desc_ready  = (st_q.state == ST_IDLE);
        fetch_start = desc_valid && desc_ready;
        case (st_q.state)
            ST_IDLE: if (fetch_start) begin
                st_d.state = ST_HUNT;
                st_d.last  = desc_last;
                st_d.irq   = desc_irq;
            end
            ST_HUNT: if (sync_strobe) begin
                st_d.state = ST_SEND;
                st_d.rts   = 1'b1;
            end
            ST_SEND: if (buf_done) begin
                st_d.state = ST_IDLE;
                if (st_q.last) st_d.rts = 1'b0;
                set_evt = st_q.irq;
            end
            default: st_d.state = ST_IDLE;
        endcase
        if (evt_clear) st_d.evt = 1'b0;
        if (set_evt)   st_d.evt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{state: ST_IDLE, rts: 1'b0, evt: 1'b0, last: 1'b0, irq: 1'b0};
        else        st_q <= st_d;
    end

    tfs_fetch #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (fetch_start),
        .start_addr (desc_addr),
        .start_len  (desc_len),
        .rd_en      (mem_rd_en),
        .rd_waddr   (mem_rd_waddr),
        .rd_data    (mem_rd_data),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .byte_pop   (byte_pop),
        .empty      (fetch_empty)
    );

    tfs_shift u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .active      (st_q.state == ST_SEND),
        .rev         (rev_bits),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .fetch_empty (fetch_empty),
        .byte_pop    (byte_pop),
        .done        (buf_done),
        .txd         (txd)
    );

    assign rts      = st_q.rts;
    assign tx_event = st_q.evt;
    assign tx_irq   = st_q.evt & evt_mask;
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker (
    input logic clk,
    input logic rst_n,
    input logic desc_valid,
    input logic desc_ready,
    input logic sync_strobe,
    input logic bit_en,
    input logic evt_clear,
    input logic mem_rd_en,
    input logic txd,
    input logic rts,
    input logic tx_event
);
    AST_IDLE_LINE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !rts |-> txd); // R1

    AST_RTS_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts) |-> $past(sync_strobe)); // R2

    AST_TXD_ON_BIT_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(txd)); // R5

    AST_EVENT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        tx_event && !evt_clear |=> tx_event); // R7

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |=> !desc_ready); // R10

    AST_READ_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !desc_ready); // R10
endmodule

bind tfs_top tfs_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .desc_valid  (desc_valid),
    .desc_ready  (desc_ready),
    .sync_strobe (sync_strobe),
    .bit_en      (bit_en),
    .evt_clear   (evt_clear),
    .mem_rd_en   (mem_rd_en),
    .txd         (txd),
    .rts         (rts),
    .tx_event    (tx_event)
);

// File: tb/sim_tfs_top.sv
module sim_tfs_top;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              desc_valid = 1'b0;
    logic              desc_ready;
    logic [ADDR_W-1:0] desc_addr = '0;
    logic [LEN_W-1:0]  desc_len = '0;
    logic              desc_last = 1'b0;
    logic              desc_irq = 1'b0;
    logic              sync_strobe = 1'b0;
    logic              bit_en = 1'b0;
    logic              rev_bits = 1'b0;
    logic              mem_rd_en;
    logic [ADDR_W-2:0] mem_rd_waddr;
    logic [15:0]       mem_rd_data = '0;
    logic              txd;
    logic              rts;
    logic              evt_clear = 1'b0;
    logic              evt_mask = 1'b0;
    logic              tx_event;
    logic              tx_irq;

    int  n_checks = 0;
    int  n_bad = 0;
    int  rd_total = 0;
    bit  finished = 1'b0;
    bit  evt_exp = 1'b0;
    bit  in_frame = 1'b0;

    always #2 clk = ~clk;

    tfs_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u0 (.*);

    function automatic logic [7:0] mb(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= {mb(2 * int'(mem_rd_waddr)), mb(2 * int'(mem_rd_waddr) + 1)};
            rd_total = rd_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(output logic t, output logic r);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        t = txd;
        r = rts;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_buf(input int addr, input int len, input bit last,
                           input bit irq, input bit rev, input int pre);
        int   r0;
        int   words;
        logic t, r;
        r0 = rd_total;
        while (!desc_ready) @(negedge clk);
        desc_valid = 1'b1;
        desc_addr  = ADDR_W'(addr);
        desc_len   = LEN_W'(len);
        desc_last  = last;
        desc_irq   = irq;
        rev_bits   = rev;
        @(negedge clk);
        desc_valid = 1'b0;
        check(desc_ready == 1'b0, "R10 ready low while held", int'(desc_ready), 0);
        repeat (4) @(negedge clk);
        for (int p = 0; p < pre; p++) begin
            tick(t, r);
            check(t == 1'b1 && r == in_frame, "R3 ones before sync", int'({t, r}), int'({1'b1, in_frame}));
        end
        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        check(rts == 1'b1, "R2 rts after sync", int'(rts), 1);
        for (int k = 0; k < len; k++) begin
            logic [7:0] b, got;
            bit rts_ok;
            b = mb(addr + k);
            rts_ok = 1'b1;
            for (int i = 0; i < 8; i++) begin
                tick(t, r);
                got[7-i] = t;
                if (r != 1'b1) rts_ok = 1'b0;
            end
            if (rev) check(got == {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]},
                           "R6 reversed byte", int'(got), int'(b));
            else     check(got == b, "R5 R4 byte stream", int'(got), int'(b));
            check(rts_ok, "R2 rts high during data", 0, 1);
        end
        tick(t, r);
        check(t == 1'b1, "R1 ones after buffer", int'(t), 1);
        if (last) check(r == 1'b0, "R2 rts low at frame end", int'(r), 0);
        else      check(r == 1'b1, "R9 rts held when chained", int'(r), 1);
        words = ((addr + len - 1) >> 1) - (addr >> 1) + 1;
        check(rd_total - r0 == words, "R4 word reads", rd_total - r0, words);
        if (irq) evt_exp = 1'b1;
        check(tx_event == evt_exp, "R7 event after buffer", int'(tx_event), int'(evt_exp));
        check(desc_ready == 1'b1, "R10 ready after buffer", int'(desc_ready), 1);
        in_frame = !last;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        logic t, r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd == 1'b1 && rts == 1'b0, "R1 reset line state", int'({txd, rts}), 2);
        check(desc_ready == 1'b1, "R10 ready at reset", int'(desc_ready), 1);
        check(tx_event == 1'b0 && tx_irq == 1'b0, "R7 no event at reset", int'(tx_event), 0);

        sync_strobe = 1'b1;
        @(negedge clk);
        sync_strobe = 1'b0;
        tick(t, r);
        check(t == 1'b1 && r == 1'b0, "R3 sync ignored when idle", int'({t, r}), 2);

        for (int rv = 0; rv < 2; rv++)
            for (int a = 0; a < 4; a++)
                for (int l = 1; l <= 4; l++)
                    run_buf(16 + a + 8 * l, l, 1'b1, (l == 2), rv[0], 1);

        run_buf(5, 10, 1'b1, 1'b0, 1'b0, 2);

        evt_mask = 1'b0;
        @(negedge clk);
        check(tx_irq == 1'b0, "R8 masked irq low", int'(tx_irq), 0);
        evt_mask = 1'b1;
        @(negedge clk);
        check(tx_irq == 1'b1, "R8 irq follows event", int'(tx_irq), 1);
        evt_clear = 1'b1;
        @(negedge clk);
        evt_clear = 1'b0;
        evt_exp = 1'b0;
        check(tx_event == 1'b0 && tx_irq == 1'b0, "R7 event cleared", int'(tx_event), 0);

        run_buf(3, 3, 1'b0, 1'b1, 1'b0, 1);
        check(tx_irq == 1'b1, "R8 irq after chained buffer", int'(tx_irq), 1);
        for (int p = 0; p < 2; p++) begin
            tick(t, r);
            check(t == 1'b1 && r == 1'b1, "R9 ones with rts between buffers", int'({t, r}), 3);
        end
        run_buf(40, 5, 1'b1, 1'b0, 1'b1, 2);
        check(tx_event == 1'b1, "R7 event kept by plain buffer", int'(tx_event), 1);
        tick(t, r);
        check(t == 1'b1 && r == 1'b0, "R1 idle after frame", int'({t, r}), 2);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule